// File: doc/BRIEF.md
# Programmable Beep Tone Burst Generator

This block produces a square-wave alert tone as a stream of signed PCM samples, one sample per sample-rate tick. A two-bit mode input selects silence, a single burst, a repeating burst pattern, or an unbroken tone. Four-bit pitch, four-bit burst-length, three-bit gap-length and five-bit loudness inputs shape the sound. A busy flag shows when the tone is audible. Adding the tone into an audio path happens downstream and is not part of this block.

Samples leave through a one-deep valid/ready register. The tick moves the timeline forward only when that register can take a new sample, meaning it is empty or being read in the same cycle. A tick that arrives while an unread sample waits with ready low is dropped. The timeline pauses for it, so burst and gap lengths count delivered samples and not raw ticks. While valid is high and ready is low, the data stays unchanged.

All timing is counted in "steps". A step is a clock on which a tick is taken.

Top module: `tone_burst_gen`

## Requirements
- R1: After reset, `smp_valid`, `smp_data` and `busy` are all zero.
- R2: With `mode` = 00 the block is silent. `busy` is low from the next clock, and every sample emitted while the mode is 00 or while not in a tone phase is zero.
- R3: With `mode` = 11 the tone starts at the next clock and stays on without a break for as long as the mode is held.
- R4: With `mode` = 10 the block alternates between two phases. A tone phase lasts (`on_len`+1)×1024 steps and a silent gap lasts (`off_len`+1)×4096 steps. The cycle repeats until the mode changes.
- R5: With `mode` = 01 a single tone phase of (`on_len`+1)×1024 steps is started only on a clock where `mode` is 01 and was not 01 on the clock before. Holding 01 after the burst ends produces no further tone. The mode must leave 01 and return to start another burst.
- R6: `busy` is high exactly on the cycles the block is in a tone phase. A sample taken in a step while `busy` is low is zero.
- R7: The tone is a square wave with a half period of 4+3×`freq_sel` steps. Each tone phase entered from silence begins with a positive half.
- R8: The amplitude for `level` L is computed as follows. Let b = 32767 >> (L div 3). The amplitude is b when L mod 3 = 0. It is b − (b>>2) + (b>>5) + (b>>6) when L mod 3 = 1, and (b>>1) + (b>>3) + (b>>7) when L mod 3 = 2. Each shift truncates. Positive halves emit +amplitude and negative halves emit −amplitude.
- R9: A step happens when `tick` is high and either `smp_valid` is low or `smp_ready` is high. On a step, `smp_valid` rises with the new sample. Without a step, a high `smp_ready` clears `smp_valid`. While `smp_valid` is high and `smp_ready` is low, `smp_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample-rate strobe |
| mode | input | 2 | 00 off, 01 single, 10 repeating, 11 continuous |
| freq_sel | input | 4 | Pitch select |
| on_len | input | 4 | Tone phase length code |
| off_len | input | 3 | Gap length code |
| level | input | 5 | Attenuation code, 2 dB per step |
| smp_valid | output | 1 | Sample available |
| smp_ready | input | 1 | Consumer takes the sample |
| smp_data | output | 16 | Signed tone sample |
| busy | output | 1 | Tone phase active |

## Verification
The hardest situation to reach is a single burst that has finished while `mode` is still held at 01. The block must stay silent there even though nothing at its inputs changes. The stimulus holds 01 for thousands of steps past the end of a burst. It then drops to 00 and returns to 01 to show a new burst starts. Phase lengths in the repeating mode are measured as run lengths of `busy`. Back-pressure is exercised with a sparse tick, a patterned ready and a long ready-low hold, all while the tone runs. A behavioural model checks every sample on every clock.

// File: rtl/tbg_pkg.sv
package tbg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TONE = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_e;

  localparam logic [1:0] MODE_OFF    = 2'b00;
  localparam logic [1:0] MODE_SINGLE = 2'b01;
  localparam logic [1:0] MODE_MULTI  = 2'b10;
  localparam logic [1:0] MODE_CONT   = 2'b11;
endpackage

// File: rtl/tbg_level.sv
module tbg_level #(
  parameter int W  = 16,
  parameter int LW = 5
) (
  input  logic [LW-1:0] level,
  output logic [W-2:0]  mag
);
  localparam logic [W-2:0] FULL = '1;

  logic [LW-1:0] grp;
  logic [1:0]    rem;
  logic [W-2:0]  base;

  // 6 dB per group of three codes, residual 0/2/4 dB by shift-and-add
  always_comb begin
    grp  = level / LW'(3);
    rem  = 2'(level % LW'(3));
    base = FULL >> grp;
    case (rem)
      2'd0:    mag = base;
      2'd1:    mag = base - (base >> 2) + (base >> 5) + (base >> 6);
      default: mag = (base >> 1) + (base >> 3) + (base >> 7);
    endcase
  end
endmodule

// File: rtl/tbg_pitch.sv
module tbg_pitch #(
  parameter int FW      = 4,
  parameter int HP_BASE = 4,
  parameter int HP_STEP = 3,
  localparam int NTAB   = 1 << FW,
  localparam int HPW    = $clog2(HP_BASE + (NTAB - 1) * HP_STEP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  input  logic [FW-1:0] sel,
  output logic          neg
);
  logic [HPW-1:0] hp_tab [NTAB];
  logic [HPW-1:0] cnt;

  generate
    for (genvar g = 0; g < NTAB; g++) begin : g_tab
      assign hp_tab[g] = HPW'(HP_BASE + g * HP_STEP);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt <= '0;
      neg <= 1'b0;
    end else if (step) begin
      if (cnt >= hp_tab[sel] - HPW'(1)) begin
        cnt <= '0;
        neg <= ~neg;
      end else begin
        cnt <= cnt + HPW'(1);
      end
    end
  end

  // R7: polarity only moves on a tone step or a restart
  assert_pitch_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !restart) |=> $stable(neg));
endmodule

// File: rtl/tbg_seq.sv
module tbg_seq
  import tbg_pkg::*;
#(
  parameter int ONW      = 4,
  parameter int OFFW     = 3,
  parameter int ON_UNIT  = 1024,
  parameter int OFF_UNIT = 4096,
  localparam int ON_MAX  = (1 << ONW) * ON_UNIT,
  localparam int OFF_MAX = (1 << OFFW) * OFF_UNIT,
  localparam int CW      = $clog2((ON_MAX > OFF_MAX ? ON_MAX : OFF_MAX) + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [1:0]      mode,
  input  logic [ONW-1:0]  on_len,
  input  logic [OFFW-1:0] off_len,
  output seq_state_e      state,
  output logic            restart,
  output logic            tone_step
);
  seq_state_e     nxt;
  logic [1:0]     mode_q;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  on_end, off_end;
  logic           on_last, off_last, single_edge, wrap;

  always_comb begin
    on_end      = CW'((int'(on_len) + 1) * ON_UNIT - 1);
    off_end     = CW'((int'(off_len) + 1) * OFF_UNIT - 1);
    on_last     = cnt >= on_end;
    off_last    = cnt >= off_end;
    single_edge = (mode == MODE_SINGLE) && (mode_q != MODE_SINGLE);
    tone_step   = adv && (state == ST_TONE) && (mode != MODE_OFF);
  end

  always_comb begin
    nxt     = state;
    restart = 1'b0;
    wrap    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (mode == MODE_CONT || mode == MODE_MULTI || single_edge) begin
          nxt     = ST_TONE;
          restart = 1'b1;
        end
      end
      ST_TONE: begin
        if (mode == MODE_OFF) begin
          nxt = ST_IDLE;
        end else if (adv && on_last) begin
          wrap = 1'b1;
          if (mode == MODE_MULTI)       nxt = ST_GAP;
          else if (mode == MODE_SINGLE) nxt = ST_IDLE;
        end
      end
      ST_GAP: begin
        if (mode == MODE_OFF) begin
          nxt = ST_IDLE;
        end else if (adv && off_last) begin
          if (mode == MODE_SINGLE) begin
            nxt = ST_IDLE;
          end else begin
            nxt     = ST_TONE;
            restart = 1'b1;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_q <= MODE_OFF;
      cnt    <= '0;
    end else begin
      state  <= nxt;
      mode_q <= mode;
      if (nxt != state || wrap)               cnt <= '0;
      else if (adv && state != ST_IDLE)       cnt <= cnt + CW'(1);
    end
  end

  // R5: a held single mode never restarts a burst
  assert_no_retrigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && mode == MODE_SINGLE && mode_q == MODE_SINGLE) |=> state != ST_TONE);
  // R3: continuous mode never leaves the tone phase
  assert_cont_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TONE && mode == MODE_CONT) |=> state == ST_TONE);
endmodule

// File: rtl/tone_burst_gen.sv
module tone_burst_gen
  import tbg_pkg::*;
#(
  parameter int W        = 16,
  parameter int FW       = 4,
  parameter int ONW      = 4,
  parameter int OFFW     = 3,
  parameter int LW       = 5,
  parameter int ON_UNIT  = 1024,
  parameter int OFF_UNIT = 4096,
  parameter int HP_BASE  = 4,
  parameter int HP_STEP  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [1:0]          mode,
  input  logic [FW-1:0]       freq_sel,
  input  logic [ONW-1:0]      on_len,
  input  logic [OFFW-1:0]     off_len,
  input  logic [LW-1:0]       level,
  output logic                smp_valid,
  input  logic                smp_ready,
  output logic signed [W-1:0] smp_data,
  output logic                busy
);
  seq_state_e          seq_state;
  logic                adv, restart, tone_step, neg;
  logic [W-2:0]        mag;
  logic signed [W-1:0] nxt_sample;

  assign adv = tick && (!smp_valid || smp_ready);

  tbg_seq #(.ONW(ONW), .OFFW(OFFW), .ON_UNIT(ON_UNIT), .OFF_UNIT(OFF_UNIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .adv(adv), .mode(mode), .on_len(on_len),
    .off_len(off_len), .state(seq_state), .restart(restart), .tone_step(tone_step)
  );

  tbg_pitch #(.FW(FW), .HP_BASE(HP_BASE), .HP_STEP(HP_STEP)) u_pitch (
    .clk(clk), .rst_n(rst_n), .restart(restart), .step(tone_step),
    .sel(freq_sel), .neg(neg)
  );

  tbg_level #(.W(W), .LW(LW)) u_level (.level(level), .mag(mag));

  always_comb begin
    if (!tone_step)  nxt_sample = '0;
    else if (neg)    nxt_sample = -$signed({1'b0, mag});
    else             nxt_sample = $signed({1'b0, mag});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_data  <= '0;
    end else if (adv) begin
      smp_valid <= 1'b1;
      smp_data  <= nxt_sample;
    end else if (smp_ready) begin
      smp_valid <= 1'b0;
    end
  end

  assign busy = (seq_state == ST_TONE);

  // R9: an unread sample is held under back-pressure
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data)));
  // R2: off mode silences the next clock
  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |=> !busy);
  // R6: a step taken outside the tone phase emits zero
  assert_silent_emit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !busy) |=> (smp_data == '0));
endmodule

// File: tb/sim_tone_burst_gen.sv
module sim_tone_burst_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [3:0] freq_sel = 4'd0;
  logic [3:0] on_len = 4'd0;
  logic [2:0] off_len = 3'd0;
  logic [4:0] level = 5'd0;
  logic smp_valid, smp_ready, busy;
  logic signed [15:0] smp_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tick_div = 1;
  bit bp_on = 0;
  bit hold_lo = 0;
  bit cmp_on = 0;
  bit done = 0;

  // reference model state
  int m_state, m_cnt, m_hc, m_neg, m_prev, m_vld, m_data;
  // busy run statistics
  int busy_total = 0, run = 0, hi_len = 0, lo_len = 0;
  bit last_busy = 0;

  always #5 clk = ~clk;

  tone_burst_gen u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .freq_sel(freq_sel),
    .on_len(on_len), .off_len(off_len), .level(level), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .busy(busy)
  );

  function automatic int amp(int l);
    int b;
    b = 32767 >> (l / 3);
    case (l % 3)
      0: return b;
      1: return b - (b >> 2) + (b >> 5) + (b >> 6);
      default: return (b >> 1) + (b >> 3) + (b >> 7);
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // stimulus strobes
  always @(negedge clk) begin
    cyc++;
    tick <= ((cyc % tick_div) == 0);
    smp_ready <= hold_lo ? 1'b0 : (bp_on ? ((cyc % 5) < 2) : 1'b1);
  end

  // behavioural reference, one update per clock
  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_hc = 0; m_neg = 0; m_prev = 0; m_vld = 0; m_data = 0;
    end else begin
      int md, hp, on_n, off_n, ns, samp;
      bit adv, snd, rst_ph, wrap, edge1;
      md    = int'(mode);
      hp    = 4 + 3 * int'(freq_sel);
      on_n  = (int'(on_len) + 1) * 1024;
      off_n = (int'(off_len) + 1) * 4096;
      adv   = tick && (!m_vld || smp_ready);
      snd   = adv && m_state == 1 && md != 0;
      samp  = snd ? (m_neg ? -amp(int'(level)) : amp(int'(level))) : 0;
      edge1 = (md == 1) && (m_prev != 1);
      ns = m_state; rst_ph = 0; wrap = 0;
      if (m_state == 0) begin
        if (md == 3 || md == 2 || edge1) begin ns = 1; rst_ph = 1; end
      end else if (m_state == 1) begin
        if (md == 0) ns = 0;
        else if (adv && m_cnt >= on_n - 1) begin
          wrap = 1;
          if (md == 2) ns = 2; else if (md == 1) ns = 0;
        end
      end else begin
        if (md == 0) ns = 0;
        else if (adv && m_cnt >= off_n - 1) begin
          if (md == 1) ns = 0; else begin ns = 1; rst_ph = 1; end
        end
      end
      if (rst_ph) begin m_hc = 0; m_neg = 0; end
      else if (snd) begin
        if (m_hc >= hp - 1) begin m_hc = 0; m_neg = 1 - m_neg; end
        else m_hc++;
      end
      if (ns != m_state || wrap) m_cnt = 0;
      else if (adv && m_state != 0) m_cnt++;
      m_state = ns;
      m_prev = md;
      if (adv) begin m_vld = 1; m_data = samp; end
      else if (smp_ready) m_vld = 0;
    end
  end

  // per-clock comparison and busy run tracking
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check("R9 valid", int'(smp_valid), m_vld);
      check("R7 R8 data", int'(smp_data), m_data);
      check("R6 busy", int'(busy), (m_state == 1) ? 1 : 0);
      if (busy) busy_total++;
      if (busy == last_busy) run++;
      else begin
        if (last_busy) hi_len = run; else lo_len = run;
        run = 1;
        last_busy = busy;
      end
    end
  end

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL R1 watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    int t0, d0;
    wait_cyc(5);
    rst_n = 1'b1;
    cmp_on = 1;
    // R1 reset state
    check("R1 valid", int'(smp_valid), 0);
    check("R1 data", int'(smp_data), 0);
    check("R1 busy", int'(busy), 0);
    wait_cyc(4);

    // R3 continuous tone keeps running past several length windows
    mode = 2'b11; on_len = 4'd0; freq_sel = 4'd0; level = 5'd0;
    wait_cyc(3000);
    check("R3 busy held", int'(busy), 1);

    // R8 amplitude for several codes
    level = 5'd0;  wait_cyc(20); check("R8 level0", (smp_data < 0) ? -int'(smp_data) : int'(smp_data), 32767);
    level = 5'd1;  wait_cyc(20); check("R8 level1", (smp_data < 0) ? -int'(smp_data) : int'(smp_data), 26110);
    level = 5'd2;  wait_cyc(20); check("R8 level2", (smp_data < 0) ? -int'(smp_data) : int'(smp_data), 20733);
    level = 5'd3;  wait_cyc(20); check("R8 level3", (smp_data < 0) ? -int'(smp_data) : int'(smp_data), 16383);
    level = 5'd31; wait_cyc(20); check("R8 level31", (smp_data < 0) ? -int'(smp_data) : int'(smp_data), 24);
    level = 5'd4;

    // R7 other pitches, compared by the model each clock
    freq_sel = 4'd15; wait_cyc(300);
    freq_sel = 4'd6;  wait_cyc(200);

    // R9 sparse ticks and patterned ready
    tick_div = 3; bp_on = 1; wait_cyc(1500);
    tick_div = 1; bp_on = 0; wait_cyc(3);
    // R9 long ready-low hold
    hold_lo = 1; wait_cyc(2);
    d0 = int'(smp_data);
    wait_cyc(10);
    check("R9 held valid", int'(smp_valid), 1);
    check("R9 held data", int'(smp_data), d0);
    hold_lo = 0; wait_cyc(5);

    // R2 off mode
    mode = 2'b00; wait_cyc(2);
    check("R2 busy low", int'(busy), 0);
    wait_cyc(5);
    check("R2 zero data", int'(smp_data), 0);

    // R5 single burst, then held mode does not retrigger
    freq_sel = 4'd2; level = 5'd0; on_len = 4'd0;
    t0 = busy_total;
    mode = 2'b01; wait_cyc(1100);
    check("R5 burst length", busy_total - t0, 1024);
    check("R5 ended", int'(busy), 0);
    t0 = busy_total;
    wait_cyc(3000);
    check("R5 no retrigger", busy_total - t0, 0);
    mode = 2'b00; wait_cyc(3);
    t0 = busy_total;
    mode = 2'b01; wait_cyc(1100);
    check("R5 rearmed burst", busy_total - t0, 1024);
    mode = 2'b00; wait_cyc(3);

    // R4 repeating bursts: 2048 on, 4096 off
    on_len = 4'd1; off_len = 3'd0; freq_sel = 4'd9; level = 5'd7;
    mode = 2'b10; wait_cyc(12500);
    check("R4 on length", hi_len, 2048);
    check("R4 off length", lo_len, 4096);
    mode = 2'b00; wait_cyc(5);
    check("R2 after multi", int'(busy), 0);

    finish_run();
  end
endmodule